// File: doc/BRIEF.md
# Direction-Resolved Synchronous FIFO

This block is a single-clock first-in/first-out buffer that decouples a producer from a consumer. Entries live in a two-port RAM with one write port and one read port. Each port is driven by its own wrapping address counter, and each counter steps only when a transfer on its own side is accepted. With the default 8-bit addresses the buffer holds 256 entries.

When the two addresses match, the buffer is either completely full or completely empty. A one-bit direction register settles which case applies. It records whether the last cycle that changed the occupancy added an entry or removed one. Full means the addresses match after a net add. Empty means they match after a net remove.

The write side is a valid/ready stream. The producer holds `push_valid` with `push_data`, and the entry is taken on a clock edge where `push_ready` is high. `push_ready` drops while the buffer is full, so the producer must wait. The read side is request-based. A `pop_req` is accepted only while the buffer is not empty. The entry appears on `pop_data`, qualified by `pop_valid`, one cycle after the accepted request. Because the consumer asks only when it wants data, the read side applies no back-pressure of its own.

Top module: `dir_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `empty`=1, `full`=0, `push_ready`=1 and `pop_valid`=0.
- R2: Entries leave in the order they were accepted, with the same data value.
- R3: `pop_valid` is high for exactly the one cycle after an edge where `pop_req` was high and `empty` was low, and `pop_data` then holds the entry; otherwise `pop_valid` is low.
- R4: After as many net accepted writes as the depth (256 by default), `full`=1 and `push_ready`=0; one write fewer leaves `full`=0.
- R5: A push offered while full is dropped: `full` stays 1 and no stored entry is overwritten.
- R6: A pop request while empty is dropped: `pop_valid` stays 0, `empty` stays 1, and no counter moves.
- R7: An accepted push and an accepted pop in the same cycle leave the occupancy and both flags unchanged.
- R8: One accepted pop from a full buffer clears `full`; removing the last entry sets `empty`.
- R9: Addresses wrap modulo the depth, and ordering is kept across the wrap.
- R10: `full` and `empty` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Producer offers `push_data` |
| push_data | input | DATA_W | Entry to store |
| push_ready | output | 1 | High when a push is accepted (not full) |
| pop_req | input | 1 | Consumer asks for the oldest entry |
| pop_data | output | DATA_W | Entry returned, registered |
| pop_valid | output | 1 | `pop_data` holds an entry this cycle |
| full | output | 1 | Buffer holds DEPTH entries |
| empty | output | 1 | Buffer holds no entries |

## Verification
The checker keeps its own occupancy count from the accepted handshakes at the ports. It therefore assumes the producer and consumer see the same clock and that `rst` is held for at least one edge before traffic starts. The properties make no assumption about offering a push while full or a pop while empty; both are treated as legal and must be dropped. The stimulus deliberately does both, including a push and a pop offered together in each boundary state, and holds `rst` high for several edges from time zero.

// File: rtl/dir_fifo_pkg.sv
package dir_fifo_pkg;
  // Last occupancy-changing cycle: net removal or net addition.
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } dir_e;
endpackage

// File: rtl/dir_fifo_ram.sv
module dir_fifo_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port: data valid the cycle after re.
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dir_fifo_ctr.sv
module dir_fifo_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  // Natural wrap modulo 2**ADDR_W.
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/dir_fifo_dir.sv
module dir_fifo_dir
  import dir_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic remove,
  input  logic addr_eq,
  output logic full,
  output logic empty
);
  dir_e dir_q, dir_d;

  always_comb begin
    dir_d = dir_q;
    unique case ({add, remove})
      2'b10:   dir_d = DIR_FILL;
      2'b01:   dir_d = DIR_DRAIN;
      default: dir_d = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dir_q <= DIR_DRAIN;
    else     dir_q <= dir_d;
  end

  assign full  = addr_eq && (dir_q == DIR_FILL);
  assign empty = addr_eq && (dir_q == DIR_DRAIN);
endmodule

// File: rtl/dir_fifo.sv
module dir_fifo #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              full,
  output logic              empty
);
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              push_acc, pop_acc, addr_eq;

  assign push_ready = !full;
  assign push_acc   = push_valid && !full;
  assign pop_acc    = pop_req && !empty;
  assign addr_eq    = (wr_addr == rd_addr);

  dir_fifo_ctr #(.ADDR_W(ADDR_W)) wr_ctr_i (
    .clk(clk), .rst(rst), .step(push_acc), .addr(wr_addr)
  );

  dir_fifo_ctr #(.ADDR_W(ADDR_W)) rd_ctr_i (
    .clk(clk), .rst(rst), .step(pop_acc), .addr(rd_addr)
  );

  dir_fifo_dir dir_i (
    .clk(clk), .rst(rst), .add(push_acc), .remove(pop_acc),
    .addr_eq(addr_eq), .full(full), .empty(empty)
  );

  dir_fifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(push_acc), .waddr(wr_addr), .wdata(push_data),
    .re(pop_acc), .raddr(rd_addr), .rdata(pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= pop_acc;
  end
endmodule

// File: rtl/dir_fifo_chk.sv
module dir_fifo_chk #(
  parameter int ADDR_W = 8
) (
  input logic clk,
  input logic rst,
  input logic push_valid,
  input logic push_ready,
  input logic pop_req,
  input logic pop_valid,
  input logic full,
  input logic empty
);
  localparam int DEPTH = 1 << ADDR_W;

  // Occupancy seen from the port handshakes only.
  logic [ADDR_W:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + ((push_valid && push_ready) ? 1'b1 : 1'b0)
                    - ((pop_req && !empty) ? 1'b1 : 1'b0);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (empty && !full && push_ready && !pop_valid));

  assert_pop_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty) |=> pop_valid);

  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !(pop_req && !empty) |=> !pop_valid);

  assert_full_at_depth_R4: assert property (@(posedge clk) disable iff (rst)
    full == (occ == DEPTH[ADDR_W:0]));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_req) |=> full);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (empty && !push_valid) |=> (empty && !pop_valid));

  assert_empty_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    empty == (occ == '0));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

bind dir_fifo dir_fifo_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
  .pop_req(pop_req), .pop_valid(pop_valid), .full(full), .empty(empty)
);

// File: tb/dir_fifo_tb.sv
module dir_fifo_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic push_ready;
  logic pop_req = 1'b0;
  logic [DATA_W-1:0] pop_data;
  logic pop_valid, full, empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  dir_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_req(pop_req), .pop_data(pop_data),
    .pop_valid(pop_valid), .full(full), .empty(empty)
  );

  // {push_valid, pop_req, push_data, exp_full, exp_empty, exp_pop_valid, exp_pop_data}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 first push
    {1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 8'h11},  // R7 push+pop, occupancy 2
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h22},  // R3
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h33},  // R8 last entry -> empty
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},  // R6 pop while empty
    {1'b1, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 8'h00},  // R6 pop refused, push taken
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // idle
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h44}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive, take one edge, sample 1 ns after it.
  task automatic step(input logic pv, input logic pr, input logic [DATA_W-1:0] pd);
    push_valid = pv;
    pop_req    = pr;
    push_data  = pd;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return DATA_W'((i * 7 + 3) & 8'hFF);
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 push_ready", push_ready, 1);
    check("R1 pop_valid", pop_valid, 0);
    rst = 1'b0;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][20], VEC[v][19], VEC[v][18:11]);
      check("R10/R8 table full", full, VEC[v][10]);
      check("R10/R8 table empty", empty, VEC[v][9]);
      check("R3 table pop_valid", pop_valid, VEC[v][8]);
      if (VEC[v][8]) check("R2 table pop_data", pop_data, VEC[v][7:0]);
    end

    // R4 fill to depth (write address passes the wrap, R9)
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, pat(i));
      if (i == DEPTH - 2) check("R4 not full one short", full, 0);
    end
    check("R4 full at depth", full, 1);
    check("R4 push_ready low", push_ready, 0);

    // R5 push while full dropped
    step(1'b1, 1'b0, 8'hEE);
    check("R5 full stays", full, 1);

    // R8 push+pop while full: pop taken, push refused
    step(1'b1, 1'b1, 8'hEE);
    check("R8 full clears", full, 0);
    check("R3 pop_valid", pop_valid, 1);
    check("R2 first entry", pop_data, pat(0));

    // Drain the rest: order and no overwrite (R5), across wrap (R9)
    for (int i = 1; i < DEPTH; i++) begin
      step(1'b0, 1'b1, '0);
      check("R9 pop_valid", pop_valid, 1);
      check("R9/R5 order", pop_data, pat(i));
    end
    check("R8 empty after drain", empty, 1);

    step(1'b0, 1'b0, '0);
    check("R3 valid drops", pop_valid, 0);

    // R7 steady push+pop at occupancy 2
    step(1'b1, 1'b0, 8'hA0);
    step(1'b1, 1'b0, 8'hA1);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, DATA_W'(8'hA2 + i));
      check("R7 full", full, 0);
      check("R7 empty", empty, 0);
      check("R7 data", pop_data, DATA_W'(8'hA0 + i));
    end
    step(1'b0, 1'b1, '0);
    check("R7 drain a", pop_data, 8'hA3);
    check("R7 not empty", empty, 0);
    step(1'b0, 1'b1, '0);
    check("R7 drain b", pop_data, 8'hA4);
    check("R8 empty", empty, 1);

    // R6 pop while empty leaves counters alone
    step(1'b0, 1'b1, '0);
    check("R6 no valid", pop_valid, 0);
    step(1'b1, 1'b0, 8'h5C);
    step(1'b0, 1'b1, '0);
    check("R6 counters intact", pop_data, 8'h5C);
    check("R6 empty again", empty, 1);

    // R1 reset mid-traffic
    step(1'b1, 1'b0, 8'h77);
    rst = 1'b1;
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
    check("R1 empty after reset", empty, 1);
    check("R1 full after reset", full, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule